// File: doc/BRIEF.md
# Pattern Lock Checker

This block sits on the receive side of a bit-error test path. It takes one serial bit per receive clock and compares the stream against a local reference. The reference can follow a pseudorandom sequence, set by a tap mask and a length of up to 32 bits, or a repetitive word of 1 to 32 bits. While hunting, the reference register takes its bits straight from the line. Once enough predictions have been correct in a row, the block declares lock. From then on the reference runs freely from its own feedback, so an errored line bit is never loaded into it.

While locked, every enabled bit adds to a bit counter, and every mismatch adds to an error counter. Both counters are 32 bits wide and stop at all ones. A snapshot request copies both counters into holding registers, which are the only counter view at the ports, and restarts the live counters. A hold input stops comparison, counting and all state changes for the cycles it is high, which supports gapped clocks. Lock is dropped when too many errors fall inside a sliding window. The window is sized so that a line running at an error rate of 10^-2 keeps lock.

Top module: `pattern_lock_checker`

## Requirements
- R1: After reset, `in_sync` is 0 and both `bit_hold` and `err_hold` are 0.
- R2: With `cfg_mode` = 0 (pseudorandom), the predicted bit is the XOR of the history bits selected by `cfg_taps`. Bit i of the mask selects the bit received i+1 enabled bits earlier. Mask bits above `cfg_len_m1` are ignored. An all-ones stream never locks against the taps 0x60 with `cfg_len_m1` = 6.
- R3: With `cfg_mode` = 1 (repetitive), the predicted bit is the bit received `cfg_len_m1`+1 enabled bits earlier. A stream with a different period does not lock.
- R4: While hunting, each enabled line bit is shifted into the reference. Lock is declared on the edge that completes 32 consecutive correct predictions, and any mismatch restarts the run from zero.
- R5: While locked, the reference shifts in its own prediction, so each errored line bit counts as exactly one error.
- R6: While locked, lock is dropped on the enabled bit that brings the error total of the last 64 enabled bits, including the current one, to 6 or more. Five errors in any such window keep lock.
- R7: While `rx_hold` is 1, the block makes no comparison, counts nothing and changes no lock state or run progress.
- R8: Counting happens only while locked. Each enabled locked bit adds 1 to the bit counter, and each mismatch on such a bit adds 1 to the error counter, including the bit that drops lock.
- R9: Both counters saturate at all ones instead of wrapping.
- R10: When `latch_req` is 1, the holding registers take the live counts from before this cycle's bit. The live counters restart holding only this cycle's increment. The holding registers change at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial line data |
| rx_hold | input | 1 | 1 = ignore this clock (gapped clocking) |
| cfg_mode | input | 1 | 0 = pseudorandom, 1 = repetitive |
| cfg_len_m1 | input | 5 | Pattern length minus one |
| cfg_taps | input | 32 | Feedback tap mask for the pseudorandom mode |
| latch_req | input | 1 | Snapshot counters and restart them |
| in_sync | output | 1 | 1 = locked to the pattern |
| bit_hold | output | CNT_W (32) | Snapshot of the bit counter |
| err_hold | output | CNT_W (32) | Snapshot of the error counter |

## Verification
The first stimulus is a constant-zero stream checked against a one-bit period. Every prediction matches, which pins the lock edge to exactly the 32nd bit. Single inserted ones then test run restart and the 5-versus-6 error window at both of its boundaries. A seven-stage pseudorandom stream carries a stray tap above the length. It shows that masking works and that sparse errors are counted once each, which tells a free-running reference apart from one reloaded from the line. An all-ones stream and a five-bit word checked against a four-bit period must never lock. Two further runs test the hold input and the saturation limit: gapped cycles carrying garbage data, and a long sparse-error run against a narrow-counter instance.

// File: rtl/pls_pkg.sv
package pls_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_t;

  typedef enum logic {
    MODE_PRBS = 1'b0,
    MODE_REP  = 1'b1
  } pat_mode_t;

endpackage

// File: rtl/pls_ref_predictor.sv
module pls_ref_predictor #(
  parameter int PAT_W = 32,
  localparam int LW   = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load_rx,
  input  logic             rx_bit,
  input  logic             cfg_mode,
  input  logic [LW-1:0]    cfg_len_m1,
  input  logic [PAT_W-1:0] cfg_taps,
  output logic             pred_bit
);
  import pls_pkg::*;

  logic [PAT_W-1:0] ref_q, ref_d;
  logic [PAT_W-1:0] len_mask, rep_tap, eff_taps;
  logic             shift_in;

  // history bit i is the bit seen i+1 enabled steps ago
  always_comb begin
    for (int i = 0; i < PAT_W; i++) begin
      len_mask[i] = (LW'(i) <= cfg_len_m1);
      rep_tap[i]  = (LW'(i) == cfg_len_m1);
    end
    eff_taps = (pat_mode_t'(cfg_mode) == MODE_REP) ? rep_tap : (cfg_taps & len_mask);
    pred_bit = ^(ref_q & eff_taps);
    shift_in = load_rx ? rx_bit : pred_bit;
    ref_d    = step ? {ref_q[PAT_W-2:0], shift_in} : ref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

endmodule

// File: rtl/pls_lock_fsm.sv
module pls_lock_fsm #(
  parameter int SYNC_RUN = 32,
  parameter int WIN      = 64,
  parameter int LOSS_THR = 6,
  localparam int RUN_W   = $clog2(SYNC_RUN + 1),
  localparam int CW      = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic miss,
  output logic locked
);
  import pls_pkg::*;

  lock_st_t         st_q, st_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [WIN-1:0]   hist_q, hist_d;
  logic [CW-1:0]    win_q, win_d, win_sum;

  always_comb begin
    st_d    = st_q;
    run_d   = run_q;
    hist_d  = hist_q;
    win_d   = win_q;
    win_sum = win_q + CW'(miss) - CW'(hist_q[WIN-1]);
    if (step) begin
      case (st_q)
        ST_HUNT: begin
          if (miss) begin
            run_d = '0;
          end else if (run_q == RUN_W'(SYNC_RUN - 1)) begin
            st_d   = ST_LOCK;
            run_d  = '0;
            hist_d = '0;
            win_d  = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end
        ST_LOCK: begin
          hist_d = {hist_q[WIN-2:0], miss};
          win_d  = win_sum;
          if (win_sum >= CW'(LOSS_THR)) begin
            st_d  = ST_HUNT;
            run_d = '0;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      run_q  <= '0;
      hist_q <= '0;
      win_q  <= '0;
    end else begin
      st_q   <= st_d;
      run_q  <= run_d;
      hist_q <= hist_d;
      win_q  <= win_d;
    end
  end

  assign locked = (st_q == ST_LOCK);

endmodule

// File: rtl/pls_sat_cnt.sv
module pls_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         snap,
  output logic [W-1:0] hold_o
);

  logic [W-1:0] live_q, live_d;
  logic [W-1:0] hold_q, hold_d;
  logic         at_max;

  always_comb begin
    at_max = &live_q;
    hold_d = snap ? live_q : hold_q;
    if (snap)                live_d = W'(inc);
    else if (inc && !at_max) live_d = live_q + 1'b1;
    else                     live_d = live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      hold_q <= '0;
    end else begin
      live_q <= live_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/pattern_lock_checker.sv
module pattern_lock_checker #(
  parameter int PAT_W    = 32,
  parameter int CNT_W    = 32,
  parameter int SYNC_RUN = 32,
  parameter int WIN      = 64,
  parameter int LOSS_THR = 6,
  localparam int LW      = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             rx_hold,
  input  logic             cfg_mode,
  input  logic [LW-1:0]    cfg_len_m1,
  input  logic [PAT_W-1:0] cfg_taps,
  input  logic             latch_req,
  output logic             in_sync,
  output logic [CNT_W-1:0] bit_hold,
  output logic [CNT_W-1:0] err_hold
);

  logic step, pred, miss, locked;
  logic [1:0]            cnt_inc;
  logic [1:0][CNT_W-1:0] cnt_hold;

  assign step = ~rx_hold;
  assign miss = rx_bit ^ pred;

  pls_ref_predictor #(.PAT_W(PAT_W)) u_pred (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .load_rx    (~locked),
    .rx_bit     (rx_bit),
    .cfg_mode   (cfg_mode),
    .cfg_len_m1 (cfg_len_m1),
    .cfg_taps   (cfg_taps),
    .pred_bit   (pred)
  );

  pls_lock_fsm #(
    .SYNC_RUN (SYNC_RUN),
    .WIN      (WIN),
    .LOSS_THR (LOSS_THR)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .miss   (miss),
    .locked (locked)
  );

  assign cnt_inc[0] = step & locked;
  assign cnt_inc[1] = step & locked & miss;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    pls_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (cnt_inc[g]),
      .snap   (latch_req),
      .hold_o (cnt_hold[g])
    );
  end

  assign in_sync  = locked;
  assign bit_hold = cnt_hold[0];
  assign err_hold = cnt_hold[1];

endmodule

// File: rtl/pattern_lock_checker_chk.sv
module pattern_lock_checker_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_hold,
  input logic             latch_req,
  input logic             in_sync,
  input logic [CNT_W-1:0] bit_hold,
  input logic [CNT_W-1:0] err_hold
);

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hold |=> $stable(in_sync));

  // R10
  snap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_req |=> ($stable(bit_hold) && $stable(err_hold)));

  // R8
  err_le_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |=> (err_hold <= bit_hold));

  // R4
  lock_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(!rx_hold));

  // R6
  drop_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> $past(!rx_hold));

endmodule

bind pattern_lock_checker pattern_lock_checker_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pattern_lock_checker_tb.sv
module pattern_lock_checker_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_bit, rx_hold, cfg_mode, latch_req;
  logic [4:0]  cfg_len_m1;
  logic [31:0] cfg_taps;
  logic        in_sync, sat_sync;
  logic [31:0] bit_hold, err_hold;
  logic [3:0]  sat_bits, sat_errs;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [6:0]  gen;

  always #10 clk = ~clk;

  pattern_lock_checker u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_hold(rx_hold),
    .cfg_mode(cfg_mode), .cfg_len_m1(cfg_len_m1), .cfg_taps(cfg_taps),
    .latch_req(latch_req), .in_sync(in_sync), .bit_hold(bit_hold), .err_hold(err_hold)
  );

  pattern_lock_checker #(.CNT_W(4)) u_sat (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_hold(rx_hold),
    .cfg_mode(cfg_mode), .cfg_len_m1(cfg_len_m1), .cfg_taps(cfg_taps),
    .latch_req(latch_req), .in_sync(sat_sync), .bit_hold(sat_bits), .err_hold(sat_errs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic b, input logic h, input logic l);
    rx_bit = b; rx_hold = h; latch_req = l;
    @(negedge clk);
  endtask

  task automatic snap();
    drive(1'b0, 1'b1, 1'b1);
  endtask

  task automatic do_reset(input logic mode, input logic [4:0] lm1, input logic [31:0] taps);
    cfg_mode = mode; cfg_len_m1 = lm1; cfg_taps = taps;
    rx_bit = 1'b0; rx_hold = 1'b1; latch_req = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic lock_zero();
    do_reset(1'b1, 5'd0, 32'h0);
    repeat (32) drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic gen_bit(input logic flip);
    logic nb;
    nb = gen[6] ^ gen[5];
    gen = {gen[5:0], nb};
    drive(nb ^ flip, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 5'd6, 32'h60);
    chk("R1 in_sync", 32'(in_sync), 0);
    chk("R1 bit_hold", bit_hold, 0);
    chk("R1 err_hold", err_hold, 0);
  endtask

  task automatic t_acquire();
    do_reset(1'b1, 5'd0, 32'h0);
    repeat (31) drive(1'b0, 1'b0, 1'b0);
    chk("R4 no lock at 31", 32'(in_sync), 0);
    drive(1'b0, 1'b0, 1'b0);
    chk("R4 lock at 32", 32'(in_sync), 1);
    do_reset(1'b1, 5'd0, 32'h0);
    repeat (20) drive(1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    repeat (32) drive(1'b0, 1'b0, 1'b0);
    chk("R4 run restarted", 32'(in_sync), 0);
    drive(1'b0, 1'b0, 1'b0);
    chk("R4 relock", 32'(in_sync), 1);
  endtask

  task automatic t_window();
    lock_zero();
    for (int k = 0; k <= 64; k++)
      drive((k % 10 == 0 && k <= 40) || k == 64, 1'b0, 1'b0);
    chk("R6 five per window keeps lock", 32'(in_sync), 1);
    snap();
    chk("R8 bits counted", bit_hold, 65);
    chk("R8 errors counted", err_hold, 6);
    lock_zero();
    for (int k = 0; k < 63; k++)
      drive((k % 10 == 0 && k <= 40), 1'b0, 1'b0);
    chk("R6 before sixth", 32'(in_sync), 1);
    drive(1'b1, 1'b0, 1'b0);
    chk("R6 sixth drops lock", 32'(in_sync), 0);
    snap();
    chk("R8 drop bit counted", bit_hold, 64);
    chk("R8 drop error counted", err_hold, 6);
    repeat (20) drive(1'b1, 1'b0, 1'b0);
    snap();
    chk("R8 no count while hunting", bit_hold, 0);
    chk("R8 no errors while hunting", err_hold, 0);
  endtask

  task automatic t_gap();
    lock_zero();
    for (int k = 0; k < 10; k++) drive(k == 3, 1'b0, 1'b0);
    for (int k = 0; k < 40; k++) drive(1'b1, 1'b1, 1'b0);
    chk("R7 lock kept under hold", 32'(in_sync), 1);
    snap();
    chk("R7 bits frozen", bit_hold, 10);
    chk("R7 errors frozen", err_hold, 1);
    do_reset(1'b1, 5'd0, 32'h0);
    repeat (31) drive(1'b0, 1'b0, 1'b0);
    repeat (10) drive(1'b1, 1'b1, 1'b0);
    chk("R7 hunting paused", 32'(in_sync), 0);
    drive(1'b0, 1'b0, 1'b0);
    chk("R7 run kept", 32'(in_sync), 1);
  endtask

  task automatic t_latch();
    lock_zero();
    repeat (9) drive(1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b1);
    chk("R10 snapshot before bit", bit_hold, 9);
    chk("R10 snapshot errors", err_hold, 0);
    snap();
    chk("R10 live kept bit", bit_hold, 1);
    chk("R10 live kept error", err_hold, 1);
  endtask

  task automatic t_sat();
    lock_zero();
    for (int k = 0; k < 260; k++) drive(k % 13 == 0, 1'b0, 1'b0);
    chk("R6 sparse errors keep lock", 32'(in_sync), 1);
    snap();
    chk("R8 long bits", bit_hold, 260);
    chk("R8 long errors", err_hold, 20);
    chk("R9 bits saturate", 32'(sat_bits), 15);
    chk("R9 errors saturate", 32'(sat_errs), 15);
  endtask

  task automatic t_prbs();
    do_reset(1'b0, 5'd6, 32'h8000_0060);
    gen = 7'h5a;
    repeat (120) gen_bit(1'b0);
    chk("R2 prbs lock with masked tap", 32'(in_sync), 1);
    snap();
    for (int k = 0; k < 100; k++) gen_bit(k == 10 || k == 50 || k == 90);
    snap();
    chk("R5 prbs bits", bit_hold, 100);
    chk("R5 single error each", err_hold, 3);
    chk("R5 lock kept", 32'(in_sync), 1);
    do_reset(1'b0, 5'd6, 32'h60);
    repeat (100) drive(1'b1, 1'b0, 1'b0);
    chk("R2 ones never lock", 32'(in_sync), 0);
  endtask

  task automatic t_rep();
    logic [4:0] pat;
    pat = 5'b01101;
    do_reset(1'b1, 5'd4, 32'h0);
    for (int k = 0; k < 60; k++) drive(pat[k % 5], 1'b0, 1'b0);
    chk("R3 period five lock", 32'(in_sync), 1);
    snap();
    for (int k = 60; k < 110; k++) drive(pat[k % 5] ^ (k == 67), 1'b0, 1'b0);
    snap();
    chk("R3 bits", bit_hold, 50);
    chk("R3 errors", err_hold, 1);
    do_reset(1'b1, 5'd3, 32'h0);
    for (int k = 0; k < 100; k++) drive(pat[k % 5], 1'b0, 1'b0);
    chk("R3 wrong period no lock", 32'(in_sync), 0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rx_bit = 1'b0; rx_hold = 1'b1; latch_req = 1'b0;
    cfg_mode = 1'b0; cfg_len_m1 = 5'd6; cfg_taps = 32'h60;
    gen = 7'h01;
    @(negedge clk);
    t_reset();
    t_acquire();
    t_window();
    t_gap();
    t_latch();
    t_sat();
    t_prbs();
    t_rep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule